// File: doc/BRIEF.md
# Ethernet PHY Basic Control and Status Registers

This block holds the two lowest management registers of a 10/100 Ethernet PHY. The control word, at address 0, drives the PHY's power-down, isolate, auto-negotiation restart, duplex and collision-test controls. It also issues a one-clock internal soft-reset pulse. The status word, at address 1, reports fixed ability bits together with live auto-negotiation complete and remote-fault indications.

Accesses come through a plain parallel port. It has an address, write data, a write strobe and a read strobe. Read data is registered and appears one clock after the read strobe. Two strap inputs are sampled at reset and set the reset values of isolate and duplex. A soft reset samples them again.

Soft reset needs two steps when the PHY is powered down. The first soft-reset write only wakes the PHY. A second soft-reset write performs the real reset. The remote-fault status bit holds any fault it sees until software reads the status word.

Top module: `phy_mgmt_regs`

## Requirements
- R1: Control bit 11 (power-down) is written and read back at address 0 and drives `pwr_down_o`. Its value after reset is 0.
- R2: If a write to address 0 has bit 15 set while power-down is 0, the next cycle shows `soft_reset_o` high for exactly one clock. In that cycle the control bits hold their defaults, with the straps sampled again. Control bit 15 reads 1 only during that pulse.
- R3: If a write to address 0 has bit 15 set while power-down is 1, it only clears power-down. It gives no soft-reset pulse and leaves every other control bit unchanged.
- R4: Writing 1 to control bit 9 raises `an_restart_o` for exactly one clock, after which bit 9 reads 0.
- R5: After reset, isolate (control bit 10, `isolate_o`) equals `strap_isolate`. Full duplex (control bit 8, `full_duplex_o`) equals the inverse of `strap_duplex`.
- R6: Collision test (control bit 7, `col_test_o`) resets to 0. Control bits 14:12 and 6:0 always read 0.
- R7: Status bits 15:11 read the ability parameter, 5'b01111 by default. Bits 10:7 read 0, bit 6 reads 1, bit 3 reads 1 and bits 2:0 read 0. Writes to address 1 change nothing.
- R8: Status bit 4 (remote fault) becomes 1 on any cycle `remote_fault_in` is 1. It stays 1 until a status read, after which it follows the input again.
- R9: Status bit 5 reports `an_complete_in` as registered one clock earlier.
- R10: `rd_data` takes the addressed word on the clock after `rd_en` and reads 0 for any other address. Writes to other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| strap_isolate | input | 1 | Isolate strap |
| strap_duplex | input | 1 | Duplex strap (1 selects half duplex) |
| an_complete_in | input | 1 | Auto-negotiation complete from link logic |
| remote_fault_in | input | 1 | Remote fault from link logic |
| pwr_down_o | output | 1 | Power-down control |
| isolate_o | output | 1 | Isolate control |
| an_restart_o | output | 1 | Auto-negotiation restart pulse |
| full_duplex_o | output | 1 | Duplex select, 1 for full |
| col_test_o | output | 1 | Collision test enable |
| soft_reset_o | output | 1 | One-clock soft-reset pulse |

## Verification
The hardest state to reach is a soft-reset write that arrives while power-down is set and other control bits hold non-default values. Reaching it needs a setup write with power-down and collision test set, and different live straps than at reset. The first soft-reset write must then leave collision test set and raise no pulse. The second must give the pulse, clear collision test, and pick up the new straps. The latch-high bit is driven for a single cycle between reads, so that only the latch can explain a 1 in the read.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DW        = 16;
  localparam int CTL_RST   = 15;
  localparam int CTL_PD    = 11;
  localparam int CTL_ISO   = 10;
  localparam int CTL_ANR   = 9;
  localparam int CTL_DUP   = 8;
  localparam int CTL_COL   = 7;
  localparam int STS_ANC   = 5;
  localparam int STS_RF    = 4;
  localparam int STS_PRE   = 6;
  localparam int STS_ANA   = 3;

  typedef struct packed {
    logic pd;
    logic iso;
    logic anr;
    logic dup;
    logic col;
  } ctrl_t;
endpackage

// File: rtl/phy_latch_high.sv
module phy_latch_high #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] held
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) held[i] <= 1'b0;
      else     held[i] <= src[i] | (held[i] & ~clear);
    end
  end
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_mgmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic          wd_rst,
  input  ctrl_t         wd,
  input  logic          strap_isolate,
  input  logic          strap_duplex,
  output ctrl_t         ctrl,
  output logic          soft_pulse,
  output logic [DW-1:0] word
);
  ctrl_t defaults;

  always_comb begin
    defaults     = '0;
    defaults.iso = strap_isolate;
    defaults.dup = ~strap_duplex;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= defaults;
      soft_pulse <= 1'b0;
    end else begin
      soft_pulse <= 1'b0;
      ctrl.anr   <= 1'b0;
      if (wr_hit) begin
        if (wd_rst && ctrl.pd) begin
          ctrl.pd <= 1'b0;
        end else if (wd_rst) begin
          ctrl       <= defaults;
          soft_pulse <= 1'b1;
        end else begin
          ctrl <= wd;
        end
      end
    end
  end

  always_comb begin
    word          = '0;
    word[CTL_RST] = soft_pulse;
    word[CTL_PD]  = ctrl.pd;
    word[CTL_ISO] = ctrl.iso;
    word[CTL_ANR] = ctrl.anr;
    word[CTL_DUP] = ctrl.dup;
    word[CTL_COL] = ctrl.col;
  end
endmodule

// File: rtl/phy_stat_reg.sv
module phy_stat_reg
  import phy_mgmt_pkg::*;
#(
  parameter logic [4:0] ABILITY = 5'b01111
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_hit,
  input  logic          an_complete_in,
  input  logic          remote_fault_in,
  output logic [DW-1:0] word
);
  logic an_q;
  logic rf_q;

  always_ff @(posedge clk) begin
    if (rst) an_q <= 1'b0;
    else     an_q <= an_complete_in;
  end

  phy_latch_high #(.WIDTH(1)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .clear (rd_hit),
    .src   (remote_fault_in),
    .held  (rf_q)
  );

  always_comb begin
    word          = '0;
    word[15:11]   = ABILITY;
    word[STS_PRE] = 1'b1;
    word[STS_ANA] = 1'b1;
    word[STS_ANC] = an_q;
    word[STS_RF]  = rf_q;
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int         ADDR_W  = 5,
  parameter logic [4:0] ABILITY = 5'b01111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  input  logic              strap_isolate,
  input  logic              strap_duplex,
  input  logic              an_complete_in,
  input  logic              remote_fault_in,
  output logic              pwr_down_o,
  output logic              isolate_o,
  output logic              an_restart_o,
  output logic              full_duplex_o,
  output logic              col_test_o,
  output logic              soft_reset_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

  logic          ctrl_wr, stat_rd;
  ctrl_t         wd, ctrl;
  logic [DW-1:0] ctrl_word, stat_word;
  logic          unused_wr_bits;

  assign ctrl_wr = wr_en && (reg_addr == A_CTRL);
  assign stat_rd = rd_en && (reg_addr == A_STAT);

  assign wd.pd  = wr_data[CTL_PD];
  assign wd.iso = wr_data[CTL_ISO];
  assign wd.anr = wr_data[CTL_ANR];
  assign wd.dup = wr_data[CTL_DUP];
  assign wd.col = wr_data[CTL_COL];
  assign unused_wr_bits = ^{wr_data[14:12], wr_data[6:0]};

  phy_ctrl_reg u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .wr_hit        (ctrl_wr),
    .wd_rst        (wr_data[CTL_RST]),
    .wd            (wd),
    .strap_isolate (strap_isolate),
    .strap_duplex  (strap_duplex),
    .ctrl          (ctrl),
    .soft_pulse    (soft_reset_o),
    .word          (ctrl_word)
  );

  phy_stat_reg #(.ABILITY(ABILITY)) u_stat (
    .clk             (clk),
    .rst             (rst),
    .rd_hit          (stat_rd),
    .an_complete_in  (an_complete_in),
    .remote_fault_in (remote_fault_in),
    .word            (stat_word)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (reg_addr)
        A_CTRL:  rd_data <= ctrl_word;
        A_STAT:  rd_data <= stat_word;
        default: rd_data <= '0;
      endcase
    end
  end

  assign pwr_down_o    = ctrl.pd;
  assign isolate_o     = ctrl.iso;
  assign an_restart_o  = ctrl.anr;
  assign full_duplex_o = ctrl.dup;
  assign col_test_o    = ctrl.col;
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       wr_data,
  input logic              wr_en,
  input logic              rd_en,
  input logic [15:0]       rd_data,
  input logic              remote_fault_in,
  input logic              pwr_down_o,
  input logic              an_restart_o,
  input logic              col_test_o,
  input logic              soft_reset_o
);
  p_soft_one_clock_r2: assert property (@(posedge clk) disable iff (rst)
    soft_reset_o |=> !soft_reset_o);

  p_soft_defaults_r2: assert property (@(posedge clk) disable iff (rst)
    soft_reset_o |-> (!pwr_down_o && !col_test_o && !an_restart_o));

  p_pd_wake_only_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_addr == ADDR_W'(0) && wr_data[15] && pwr_down_o)
      |=> (!pwr_down_o && !soft_reset_o));

  p_restart_self_clear_r4: assert property (@(posedge clk) disable iff (rst)
    an_restart_o |=> !an_restart_o);

  p_status_const_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_addr == ADDR_W'(1))
      |=> (rd_data[6] && rd_data[3] && rd_data[10:7] == 4'b0 && rd_data[2:0] == 3'b0));

  p_rf_latch_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_addr == ADDR_W'(1) && !$past(rst) && $past(remote_fault_in))
      |=> rd_data[4]);

  p_reserved_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_addr == ADDR_W'(0)) |=> (rd_data[14:12] == 3'b0 && rd_data[6:0] == 7'b0));
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk             (clk),
  .rst             (rst),
  .reg_addr        (reg_addr),
  .wr_data         (wr_data),
  .wr_en           (wr_en),
  .rd_en           (rd_en),
  .rd_data         (rd_data),
  .remote_fault_in (remote_fault_in),
  .pwr_down_o      (pwr_down_o),
  .an_restart_o    (an_restart_o),
  .col_test_o      (col_test_o),
  .soft_reset_o    (soft_reset_o)
);

// File: tb/phy_mgmt_regs_tb_top.sv
module phy_mgmt_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        strap_isolate = 1'b1, strap_duplex = 1'b1;
  logic        an_complete_in = 1'b0, remote_fault_in = 1'b0;
  logic        pwr_down_o, isolate_o, an_restart_o, full_duplex_o, col_test_o, soft_reset_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phy_mgmt_regs dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .strap_isolate(strap_isolate), .strap_duplex(strap_duplex),
    .an_complete_in(an_complete_in), .remote_fault_in(remote_fault_in),
    .pwr_down_o(pwr_down_o), .isolate_o(isolate_o), .an_restart_o(an_restart_o),
    .full_duplex_o(full_duplex_o), .col_test_o(col_test_o), .soft_reset_o(soft_reset_o)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [4:0] a, logic [15:0] d);
    @(negedge clk); reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    do_read(5'd0, v);
    check("R5 ctrl after reset", v, 16'h0400);
    check("R1 pwr_down_o reset", {15'b0, pwr_down_o}, 16'h0);
    check("R5 isolate_o/full_duplex_o", {14'b0, isolate_o, full_duplex_o}, 16'h2);
    check("R6 col_test_o reset", {15'b0, col_test_o}, 16'h0);
    do_read(5'd1, v);
    check("R7 status after reset", v, 16'h7848);
  endtask

  task automatic t_ctrl_rw;
    logic [15:0] v;
    do_write(5'd0, 16'hFFFF & ~16'h8200);
    do_read(5'd0, v);
    check("R6 reserved read 0, R1 pd set", v, 16'h0D80);
    check("R1 pwr_down_o", {15'b0, pwr_down_o}, 16'h1);
    do_write(5'd0, 16'h0000);
    do_read(5'd0, v);
    check("R1 cleared", v, 16'h0000);
  endtask

  task automatic t_restart;
    logic [15:0] v;
    do_write(5'd0, 16'h0200);
    check("R4 pulse high", {15'b0, an_restart_o}, 16'h1);
    @(negedge clk);
    check("R4 pulse low", {15'b0, an_restart_o}, 16'h0);
    do_read(5'd0, v);
    check("R4 bit9 reads 0", v, 16'h0000);
  endtask

  task automatic t_pd_soft;
    logic [15:0] v;
    strap_isolate = 1'b0; strap_duplex = 1'b0;
    do_write(5'd0, 16'h0880);
    do_write(5'd0, 16'h8000);
    check("R3 no pulse", {15'b0, soft_reset_o}, 16'h0);
    do_read(5'd0, v);
    check("R3 only pd cleared", v, 16'h0080);
    do_write(5'd0, 16'h8000);
    check("R2 pulse high", {15'b0, soft_reset_o}, 16'h1);
    @(negedge clk);
    check("R2 pulse one clock", {15'b0, soft_reset_o}, 16'h0);
    do_read(5'd0, v);
    check("R2 defaults with new straps", v, 16'h0100);
  endtask

  task automatic t_status;
    logic [15:0] v;
    do_write(5'd1, 16'hFFFF);
    do_read(5'd1, v);
    check("R7 write ignored", v, 16'h7848);
    do_read(5'd0, v);
    check("R7 ctrl untouched by status write", v, 16'h0100);
    do_write(5'd2, 16'h0880);
    do_read(5'd0, v);
    check("R10 other addr write ignored", v, 16'h0100);
    do_read(5'd2, v);
    check("R10 other addr reads 0", v, 16'h0000);
    an_complete_in = 1'b1;
    @(negedge clk);
    do_read(5'd1, v);
    check("R9 an complete", v, 16'h7868);
    an_complete_in = 1'b0;
    @(negedge clk);
    do_read(5'd1, v);
    check("R9 an clear", v, 16'h7848);
  endtask

  task automatic t_latch;
    logic [15:0] v;
    @(negedge clk); remote_fault_in = 1'b1;
    @(negedge clk); remote_fault_in = 1'b0;
    repeat (3) @(negedge clk);
    do_read(5'd1, v);
    check("R8 latched", v, 16'h7858);
    do_read(5'd1, v);
    check("R8 cleared by read", v, 16'h7848);
    remote_fault_in = 1'b1;
    @(negedge clk);
    do_read(5'd1, v);
    check("R8 live fault", v, 16'h7858);
    do_read(5'd1, v);
    check("R8 persists while input high", v, 16'h7858);
    remote_fault_in = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl_rw();
    t_restart();
    t_pd_soft();
    t_status();
    t_latch();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule